// File: doc/BRIEF.md
# Toggle-Handshake Global Error Interrupt Unit

This block keeps two 32-bit registers, an error word and an acknowledge word. A cause is pending while its bit differs between them. Hardware raises causes with a masked error strobe, and software clears them by writing the acknowledge word. A cause is raised by flipping its bit in the error word, not by setting a status bit. A cause that is already pending is never flipped a second time, so a repeated report cannot cancel an unacknowledged one.

The block also drives four single-cycle interrupt pulse lines. The global error line fires when new causes appear. The event queue line and the command sync line follow their own request inputs. The page-request line is not supported. Enable inputs gate the lines that have one. Bus decoding and queue logic live outside this block.

Top module: `tei_unit`

## Requirements
- R1: `pendVec` always equals `errReg` XOR `ackReg`.
- R2: When `errReq` is high in a cycle, `errReg` after the next clock edge equals its old value XOR (`errMask` AND NOT the old `pendVec`). Bits that were already pending are never flipped.
- R3: If `errReq` is high but no mask bit is newly raised, `errReg` is unchanged and `gerrPulse` stays low.
- R4: `gerrPulse` is high for the cycle after a request that raised at least one new bit, and only if `gerrIrqEn` was high in the request cycle.
- R5: A write (`ackWrEn` high) stores `ackWrData` into `ackReg` unchanged at the next edge, even if it flips bits that are not pending.
- R6: `evtPulse` is high in the cycle after `evtIrqReq`, only if `evtIrqEn` was high in the request cycle.
- R7: `syncPulse` is high in the cycle after every `syncIrqReq`, whatever the enables are.
- R8: `pageReqPulse` never goes high, even when `pageReqIrq` is asserted.
- R9: Every pulse output is registered and lasts exactly one cycle for each request cycle.
- R10: After reset, `errReg`, `ackReg`, `pendVec` and all pulse and flag outputs are zero.
- R11: `ackBadFlip` is high for the cycle after an acknowledge write that flips at least one bit that was not pending. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| errReq | input | 1 | Error report strobe |
| errMask | input | 32 | Causes reported with `errReq` |
| gerrIrqEn | input | 1 | Global error line enable |
| evtIrqReq | input | 1 | Event queue interrupt request |
| evtIrqEn | input | 1 | Event queue line enable |
| syncIrqReq | input | 1 | Command sync interrupt request |
| pageReqIrq | input | 1 | Page-request interrupt request (unsupported) |
| ackWrEn | input | 1 | Acknowledge register write strobe |
| ackWrData | input | 32 | Acknowledge register write data |
| errReg | output | 32 | Error word |
| ackReg | output | 32 | Acknowledge word |
| pendVec | output | 32 | Pending causes |
| gerrPulse | output | 1 | Global error interrupt pulse |
| evtPulse | output | 1 | Event queue interrupt pulse |
| syncPulse | output | 1 | Command sync interrupt pulse |
| pageReqPulse | output | 1 | Page-request interrupt pulse (always low) |
| ackBadFlip | output | 1 | Diagnostic: last acknowledge write flipped non-pending bits |

## Verification
The assertions check on every cycle that:
- pending bits are never flipped again by a new report,
- an empty report leaves the error word and the global line quiet,
- each pulse needs its enable and request one cycle earlier,
- the command sync line always answers,
- acknowledge writes land unchanged,
- the diagnostic flag only follows a write.

Only the bench's scenarios can show a few other behaviours:
- the exact XOR result of the error word when reports and acknowledge writes overlap,
- that the page-request line stays low,
- the reset state,
- that a pulse drops after one cycle.

The bench shows these by comparing every output to a behavioural model on each clock.

// File: rtl/tei_pkg.sv
package tei_pkg;
  localparam int unsigned ERR_W = 32;
  localparam int unsigned NSRC  = 4;
  localparam int unsigned SRC_GERR = 0;
  localparam int unsigned SRC_EVT  = 1;
  localparam int unsigned SRC_SYNC = 2;
  localparam int unsigned SRC_PAGE = 3;

  typedef struct packed {
    logic flipErr;
    logic loadAck;
  } tei_strobe_t;
endpackage

// File: rtl/tei_ctrl.sv
module tei_ctrl
  import tei_pkg::*;
#(
  parameter int unsigned WIDTH = ERR_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pendVec,
  input  logic             errReq,
  input  logic [WIDTH-1:0] errMask,
  input  logic             gerrIrqEn,
  input  logic             evtIrqReq,
  input  logic             evtIrqEn,
  input  logic             syncIrqReq,
  input  logic             pageReqIrq,
  input  logic             ackWrEn,
  output tei_strobe_t      strobe,
  output logic [WIDTH-1:0] flipBits,
  output logic [NSRC-1:0]  pulseVec
);
  logic [NSRC-1:0] srcReq;
  logic [NSRC-1:0] srcGate;
  logic            anyNew;

  always_comb begin
    flipBits = errMask & ~pendVec;
    anyNew   = errReq && (|flipBits);
    strobe.flipErr = anyNew;
    strobe.loadAck = ackWrEn;
    srcReq[SRC_GERR]  = anyNew;
    srcGate[SRC_GERR] = gerrIrqEn;
    srcReq[SRC_EVT]   = evtIrqReq;
    srcGate[SRC_EVT]  = evtIrqEn;
    srcReq[SRC_SYNC]  = syncIrqReq;
    srcGate[SRC_SYNC] = 1'b1;
    srcReq[SRC_PAGE]  = pageReqIrq;
    srcGate[SRC_PAGE] = 1'b0;
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_pulse
    always_ff @(posedge clk) begin
      if (!rstN) pulseVec[s] <= 1'b0;
      else       pulseVec[s] <= srcReq[s] & srcGate[s];
    end
  end

  // R6: event pulse needs request and enable one cycle earlier
  p_evt_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    pulseVec[SRC_EVT] |-> $past(evtIrqReq && evtIrqEn));
  // R7: command sync always answers
  p_sync_always_r7: assert property (@(posedge clk) disable iff (!rstN)
    syncIrqReq |=> pulseVec[SRC_SYNC]);
  // R4: global error pulse needs enable one cycle earlier
  p_gerr_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    pulseVec[SRC_GERR] |-> $past(gerrIrqEn && errReq));
endmodule

// File: rtl/tei_dpath.sv
module tei_dpath
  import tei_pkg::*;
#(
  parameter int unsigned WIDTH = ERR_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  tei_strobe_t      strobe,
  input  logic [WIDTH-1:0] flipBits,
  input  logic [WIDTH-1:0] ackWrData,
  output logic [WIDTH-1:0] errReg,
  output logic [WIDTH-1:0] ackReg,
  output logic [WIDTH-1:0] pendVec,
  output logic             ackBadFlip
);
  logic [WIDTH-1:0] ackDelta;

  always_comb begin
    pendVec  = errReg ^ ackReg;
    ackDelta = (ackReg ^ ackWrData) & ~pendVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errReg     <= '0;
      ackReg     <= '0;
      ackBadFlip <= 1'b0;
    end else begin
      if (strobe.flipErr) errReg <= errReg ^ flipBits;
      if (strobe.loadAck) ackReg <= ackWrData;
      ackBadFlip <= strobe.loadAck && (|ackDelta);
    end
  end

  // R5: acknowledge data stored unchanged
  p_ack_store_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadAck |=> ackReg == $past(ackWrData));
  // R11: diagnostic flag only follows a write
  p_diag_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    ackBadFlip |-> $past(strobe.loadAck));
endmodule

// File: rtl/tei_unit.sv
module tei_unit
  import tei_pkg::*;
#(
  parameter int unsigned WIDTH = ERR_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             errReq,
  input  logic [WIDTH-1:0] errMask,
  input  logic             gerrIrqEn,
  input  logic             evtIrqReq,
  input  logic             evtIrqEn,
  input  logic             syncIrqReq,
  input  logic             pageReqIrq,
  input  logic             ackWrEn,
  input  logic [WIDTH-1:0] ackWrData,
  output logic [WIDTH-1:0] errReg,
  output logic [WIDTH-1:0] ackReg,
  output logic [WIDTH-1:0] pendVec,
  output logic             gerrPulse,
  output logic             evtPulse,
  output logic             syncPulse,
  output logic             pageReqPulse,
  output logic             ackBadFlip
);
  tei_strobe_t      strobe;
  logic [WIDTH-1:0] flipBits;
  logic [NSRC-1:0]  pulseVec;

  tei_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .pendVec(pendVec), .errReq(errReq),
    .errMask(errMask), .gerrIrqEn(gerrIrqEn), .evtIrqReq(evtIrqReq),
    .evtIrqEn(evtIrqEn), .syncIrqReq(syncIrqReq), .pageReqIrq(pageReqIrq),
    .ackWrEn(ackWrEn), .strobe(strobe), .flipBits(flipBits),
    .pulseVec(pulseVec)
  );

  tei_dpath #(.WIDTH(WIDTH)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .flipBits(flipBits),
    .ackWrData(ackWrData), .errReg(errReg), .ackReg(ackReg),
    .pendVec(pendVec), .ackBadFlip(ackBadFlip)
  );

  assign gerrPulse    = pulseVec[SRC_GERR];
  assign evtPulse     = pulseVec[SRC_EVT];
  assign syncPulse    = pulseVec[SRC_SYNC];
  assign pageReqPulse = pulseVec[SRC_PAGE];

  // R2: pending bits of the error word are never flipped by a report
  p_no_retoggle_r2: assert property (@(posedge clk) disable iff (!rstN)
    errReq |=> ((errReg ^ $past(errReg)) & $past(pendVec)) == '0);
  // R3: an empty report changes nothing and stays quiet
  p_quiet_report_r3: assert property (@(posedge clk) disable iff (!rstN)
    (errReq && ((errMask & ~pendVec) == '0)) |=> (errReg == $past(errReg)) && !gerrPulse);
endmodule

// File: tb/tei_unit_tb_top.sv
module tei_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        errReq = 0, gerrIrqEn = 0, evtIrqReq = 0, evtIrqEn = 0;
  logic        syncIrqReq = 0, pageReqIrq = 0, ackWrEn = 0;
  logic [31:0] errMask = '0, ackWrData = '0;
  logic [31:0] errReg, ackReg, pendVec;
  logic        gerrPulse, evtPulse, syncPulse, pageReqPulse, ackBadFlip;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [31:0] mErr = '0, mAck = '0;
  logic        mGerr = 0, mEvt = 0, mSync = 0, mDiag = 0;

  always #4 clk = ~clk;

  tei_unit dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("R2 errReg", errReg, mErr);
    chk("R5 ackReg", ackReg, mAck);
    chk("R1 pendVec", pendVec, mErr ^ mAck);
    chk("R4 gerrPulse", {31'b0, gerrPulse}, {31'b0, mGerr});
    chk("R6 evtPulse", {31'b0, evtPulse}, {31'b0, mEvt});
    chk("R7 syncPulse", {31'b0, syncPulse}, {31'b0, mSync});
    chk("R8 pageReqPulse", {31'b0, pageReqPulse}, 32'b0);
    chk("R11 ackBadFlip", {31'b0, ackBadFlip}, {31'b0, mDiag});
  endtask

  // One cycle: drive at negedge, model the edge, compare after it.
  task automatic step(input logic eReq, input logic [31:0] mask, input logic gEn,
                      input logic evR, input logic evE, input logic syR,
                      input logic pgR, input logic aWr, input logic [31:0] aDat);
    logic [31:0] pend, newBits;
    errReq = eReq; errMask = mask; gerrIrqEn = gEn; evtIrqReq = evR;
    evtIrqEn = evE; syncIrqReq = syR; pageReqIrq = pgR;
    ackWrEn = aWr; ackWrData = aDat;
    pend    = mErr ^ mAck;
    newBits = eReq ? (mask & ~pend) : 32'b0;
    @(posedge clk); #1;
    cyc++;
    mGerr = (newBits != 0) && gEn;
    mEvt  = evR && evE;
    mSync = syR;
    mDiag = aWr && ((((mAck ^ aDat) & ~pend)) != 0);
    mErr  = mErr ^ newBits;
    if (aWr) mAck = aDat;
    compareAll();
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R10: reset state
    chk("R10 errReg reset", errReg, 0);
    chk("R10 ackReg reset", ackReg, 0);
    chk("R10 pendVec reset", pendVec, 0);
    chk("R10 pulses reset", {28'b0, gerrPulse, evtPulse, syncPulse, ackBadFlip}, 0);
    // raise bits 0 and 4 with enable
    step(1, 32'h11, 1, 0, 0, 0, 0, 0, 0);
    // R9: pulse gone next cycle
    idle();
    chk("R9 gerr one cycle", {31'b0, gerrPulse}, 0);
    // R3: report of already-pending bits only
    step(1, 32'h01, 1, 0, 0, 0, 0, 0, 0);
    chk("R3 errReg unchanged", errReg, 32'h11);
    chk("R3 no gerr pulse", {31'b0, gerrPulse}, 0);
    // partial overlap, enable off
    step(1, 32'h13, 0, 0, 0, 0, 0, 0, 0);
    chk("R4 disabled no pulse", {31'b0, gerrPulse}, 0);
    chk("R2 only bit1 flips", errReg, 32'h13);
    // acknowledge bit 0 only
    step(0, 0, 0, 0, 0, 0, 0, 1, 32'h01);
    chk("R1 pend after ack", pendVec, 32'h12);
    // bad-flip write (bit 8 not pending)
    step(0, 0, 0, 0, 0, 0, 0, 1, 32'h101);
    chk("R11 flag on bad flip", {31'b0, ackBadFlip}, 1);
    chk("R5 stored as-is", ackReg, 32'h101);
    // bit 8 now pending via ack; report on bit 8 must not flip it
    step(1, 32'h100, 1, 0, 0, 0, 0, 0, 0);
    chk("R2 ack-pending bit kept", errReg, 32'h13);
    // report overlapped with ack write
    step(1, 32'hF000_0000, 1, 0, 0, 0, 0, 1, 32'h113);
    // event and sync gating, page never
    step(0, 0, 0, 1, 0, 0, 1, 0, 0);
    chk("R6 evt disabled", {31'b0, evtPulse}, 0);
    chk("R8 page never", {31'b0, pageReqPulse}, 0);
    step(0, 0, 0, 1, 1, 1, 1, 0, 0);
    chk("R6 evt enabled", {31'b0, evtPulse}, 1);
    chk("R7 sync fires", {31'b0, syncPulse}, 1);
    step(0, 0, 0, 0, 1, 1, 0, 0, 0);
    chk("R9 evt dropped", {31'b0, evtPulse}, 0);
    // back-to-back sync pulses and a pseudo-random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], $urandom & 32'h0000_FFFF, r[1], r[2], r[3], r[4], r[5], r[6] & r[7],
           $urandom & 32'h0000_FFFF);
    end
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule